// File: doc/BRIEF.md
# Program/Erase Completion Status Reporter

This block sits in the read-data path of a byte-wide flash controller model. When no internal program or erase operation is running, a read returns the array byte unchanged. While an operation is busy, a read returns a status byte instead, which carries two independent completion indicators. The polling bit shows the complement of the corresponding bit of the byte most recently loaded for programming, or 0 during an erase. The toggle bit flips with every read.

A host can start polling at any point during the busy period, with no setup step. It watches either indicator until the polling bit matches its own data or the toggle bit stops changing. The controller supplies the busy flag, the operation type, program-load strobes and the array read data. The controller also owns the operation timing and the array storage.

Read results are registered. A read strobe in one cycle updates `rd_data_o` on the following clock edge, and the output holds its value until the next read.

Top module: `pe_status_reporter`

## Requirements
- R1: While `rst_n` is low, `rd_data_o` is 0. The toggle state returns to its initial value (0), so the first busy read after reset shows 0 on bit 6.
- R2: A read with `busy_i` low returns `arr_data_i` on all eight bits on the next edge.
- R3: A read with `busy_i` high and `op_erase_i` = 0 (program) returns the complement of bit 7 of the last loaded program byte on bit 7.
- R4: A read with `busy_i` high and `op_erase_i` = 1 (erase) returns 0 on bit 7.
- R5: During busy, bit 6 of successive reads alternates. The first read of each operation returns 0, which includes a read in the very first busy cycle.
- R6: During busy, bits 5 to 0 of a read are 0, whatever the array data or the loaded byte contain.
- R7: Without a read strobe, `rd_data_o` holds its value, and the toggle state does not advance.
- R8: Whenever `busy_i` is low, the toggle state returns to 0, so each new operation starts its toggle sequence afresh.
- R9: Each `pgm_load_i` pulse captures `pgm_data_i`, and the last pulse before a program read is the one that determines bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Internal operation in progress |
| op_erase_i | input | 1 | 1 = erase operation, 0 = byte program |
| pgm_load_i | input | 1 | Strobe capturing the byte loaded for programming |
| pgm_data_i | input | 8 | Byte loaded for programming |
| rd_i | input | 1 | Host read strobe |
| arr_data_i | input | 8 | Array read data |
| rd_data_o | output | 8 | Byte returned to the host |

## Verification
The hardest case to reach is the toggle restart. It requires a read in the same cycle that `busy_i` rises, right after a previous operation left the toggle state at 1. The stimulus table ends one program operation after an odd number of reads. It then drops busy and raises it again with an immediate read, and expects bit 6 to be 0. A gap row without a read inside a busy period shows that the toggle does not advance silently. A sequence of back-to-back loads before a program read shows that only the last loaded byte is used.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] rdata;
    } out_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] pgm_byte;
    } latch_state_t;

    typedef struct packed {
        logic tog;
    } tog_state_t;
endpackage

// File: rtl/pe_poll_latch.sv
module pe_poll_latch
    import pe_status_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] byte_o
);
    logic [DATA_W-1:0] byte_d, byte_q;

    always_comb begin
        byte_d = byte_q;
        if (load_i) byte_d = data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) byte_q <= '0;
        else        byte_q <= byte_d;
    end

    assign byte_o = byte_q;

    // R9: a load strobe captures the presented byte
    p_load_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> byte_o == $past(data_i));
endmodule

// File: rtl/pe_toggle_unit.sv
module pe_toggle_unit
    import pe_status_pkg::*;
#(
    parameter logic TOGGLE_INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic rd_i,
    output logic tog_o
);
    tog_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!busy_i)   st_d.tog = TOGGLE_INIT;
        else if (rd_i) st_d.tog = ~st_q.tog;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.tog <= TOGGLE_INIT;
        else        st_q     <= st_d;
    end

    assign tog_o = st_q.tog;

    // R5: every busy read flips the toggle
    p_flip_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && rd_i) |=> tog_o != $past(tog_o));
    // R7: no read during busy keeps the toggle
    p_hold_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !rd_i) |=> $stable(tog_o));
    // R8: idle forces the initial value
    p_idle_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |=> tog_o == TOGGLE_INIT);
endmodule

// File: rtl/pe_status_mux.sv
module pe_status_mux #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned POLL_BIT   = 7,
    parameter int unsigned TOGGLE_BIT = 6
) (
    input  logic              op_erase_i,
    input  logic [DATA_W-1:0] pgm_byte_i,
    input  logic              tog_i,
    output logic [DATA_W-1:0] status_o
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b == POLL_BIT) begin : g_poll
            assign status_o[b] = op_erase_i ? 1'b0 : ~pgm_byte_i[b];
        end else if (b == TOGGLE_BIT) begin : g_tog
            assign status_o[b] = tog_i;
        end else begin : g_zero
            assign status_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/pe_status_reporter.sv
module pe_status_reporter
    import pe_status_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned POLL_BIT    = 7,
    parameter int unsigned TOGGLE_BIT  = 6,
    parameter logic        TOGGLE_INIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              op_erase_i,
    input  logic              pgm_load_i,
    input  logic [DATA_W-1:0] pgm_data_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] arr_data_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam logic [DATA_W-1:0] OTHER_MASK =
        ~((DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOGGLE_BIT));

    logic [DATA_W-1:0] pgm_byte;
    logic              tog;
    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    pe_poll_latch #(.DATA_W(DATA_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .load_i(pgm_load_i),
        .data_i(pgm_data_i), .byte_o(pgm_byte)
    );

    pe_toggle_unit #(.TOGGLE_INIT(TOGGLE_INIT)) u_tog (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .rd_i(rd_i), .tog_o(tog)
    );

    pe_status_mux #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT)) u_mux (
        .op_erase_i(op_erase_i), .pgm_byte_i(pgm_byte), .tog_i(tog), .status_o(status)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (rd_i) rdata_d = busy_i ? status : arr_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rd_data_o = rdata_q;

    // R2: idle read passes array data
    p_idle_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_i && !busy_i)) |-> rd_data_o == $past(arr_data_i));
    // R4: erase polling bit reads 0
    p_erase_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_i && busy_i && op_erase_i)) |-> !rd_data_o[POLL_BIT]);
    // R6: unused bits are 0 while busy
    p_others_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_i && busy_i)) |-> (rd_data_o & OTHER_MASK) == '0);
    // R7: output holds without a read
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!rd_i)) |-> $stable(rd_data_o));
endmodule

// File: tb/pe_status_reporter_tb.sv
module pe_status_reporter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 33;

    // fields: busy, erase, load, ldat[8], rd, arr[8], chk, exp[8], req[4]
    function automatic logic [VW-1:0] mkv(logic b, logic e, logic l, logic [7:0] ld,
                                          logic r, logic [7:0] a, logic c,
                                          logic [7:0] x, logic [3:0] q);
        return {b, e, l, ld, r, a, c, x, q};
    endfunction

    localparam int NV = 19;
    localparam logic [VW-1:0] VEC [NV] = '{
        mkv(0,0,0,8'h00,1,8'hA5,1,8'hA5,2),  // idle read
        mkv(0,0,1,8'h3C,0,8'h00,0,8'h00,9),  // load 3C
        mkv(0,0,0,8'h00,1,8'h5A,1,8'h5A,2),
        mkv(1,0,0,8'h00,1,8'hFF,1,8'h80,3),  // first busy read, same cycle as rise
        mkv(1,0,0,8'h00,1,8'hFF,1,8'hC0,5),
        mkv(1,0,0,8'h00,0,8'hFF,1,8'hC0,7),  // gap: hold
        mkv(1,0,0,8'h00,1,8'hFF,1,8'h80,7),  // toggle did not advance in gap
        mkv(0,0,0,8'h00,1,8'h3C,1,8'h3C,2),  // done: true data
        mkv(0,0,1,8'h9E,0,8'h00,1,8'h3C,7),
        mkv(1,0,0,8'h00,1,8'hFF,1,8'h00,8),  // restart toggle at 0
        mkv(1,0,0,8'h00,1,8'hFF,1,8'h40,5),
        mkv(0,0,0,8'h00,0,8'h00,0,8'h00,8),
        mkv(1,1,0,8'h00,1,8'h12,1,8'h00,4),  // erase
        mkv(1,1,0,8'h00,1,8'h12,1,8'h40,4),
        mkv(0,0,0,8'h00,1,8'hFF,1,8'hFF,2),
        mkv(0,0,1,8'h80,0,8'h00,0,8'h00,9),
        mkv(0,0,1,8'h7F,0,8'h00,0,8'h00,9),
        mkv(1,0,0,8'h00,1,8'h55,1,8'h80,6),  // last load wins; low bits 0
        mkv(0,0,0,8'h00,1,8'h00,1,8'h00,2)
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic busy = 1'b0, op_erase = 1'b0, pgm_load = 1'b0, rd = 1'b0;
    logic [7:0] pgm_data = '0, arr_data = '0;
    logic [7:0] rd_data;
    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pe_status_reporter u_dut (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .op_erase_i(op_erase),
        .pgm_load_i(pgm_load), .pgm_data_i(pgm_data), .rd_i(rd),
        .arr_data_i(arr_data), .rd_data_o(rd_data)
    );

    function automatic string req_name(logic [3:0] q);
        case (q)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string rq, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", rq, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state, even with a read pending
        rd = 1'b1; arr_data = 8'hEE; busy = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", rd_data, 8'h00);
        rd = 1'b0; busy = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            {busy, op_erase, pgm_load, pgm_data, rd, arr_data} = VEC[i][VW-1:13];
            @(negedge clk);
            if (VEC[i][12]) check(req_name(VEC[i][3:0]), rd_data, VEC[i][11:4]);
        end

        // R1: reset mid-operation leaves toggle at its start value
        busy = 1'b1; op_erase = 1'b1; rd = 1'b1;
        @(negedge clk);
        check("R5", rd_data, 8'h00);
        rst_n = 1'b0; rd = 1'b0;
        @(negedge clk);
        check("R1", rd_data, 8'h00);
        rst_n = 1'b1; rd = 1'b1;
        @(negedge clk);
        check("R1", rd_data, 8'h00);
        @(negedge clk);
        check("R5", rd_data, 8'h40);
        rd = 1'b0; busy = 1'b0;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule